// File: doc/BRIEF.md
# Two-Symbol 8b/10b Transmit Framer

This block turns a stream of 16-bit words into a serial 8b/10b line. Each reference-clock period it takes one word and two qualifier bits, an enable and an error flag, and builds a 20-bit group from two 10-bit symbols. It then sends that group one bit per cycle. The qualifier pair picks one of four group kinds. A word is sent as two data symbols. A link idle sends a comma followed by a disparity-correcting character. A carrier-extension pattern and an error-propagation pattern each repeat one control symbol twice.

The block runs on the bit-rate clock. The reference clock is modelled as every twentieth edge, and the `word_req` output marks that edge. The word source presents a new word while `word_req` is high. Running disparity passes from the low-byte encoder to the high-byte encoder and on to the next group, so the line stays DC balanced. A loopback control silences the serial output and drops its output enable. This is the digital equivalent of a tri-stated driver.

Top module: `dual_byte_tx_framer`

## Requirements
- R1: `word_req` is high for exactly one cycle in every 20 cycles. The inputs `tx_word`, `tx_en` and `tx_err` are captured on the rising edge where `word_req` is high.
- R2: A word captured on one `word_req` edge is loaded on the following `word_req` edge, 20 cycles later. It appears on `ser_out` one bit per cycle from that edge onward.
- R3: With `tx_en`=1 and `tx_err`=0, `tx_word[7:0]` becomes the first symbol and `tx_word[15:8]` the second. A byte maps to Dx.y with x = byte[4:0] and y = byte[7:5]. Each symbol is sent in the order a,b,c,d,e,i,f,g,h,j.
- R4: Running disparity starts from the previous group's ending value. It is updated by the first symbol and then by the second. Every symbol has five ones, or six ones when disparity is negative, or four ones when it is positive.
- R5: With `tx_en`=0 and `tx_err`=0, the group is K28.5 followed by D16.2 if disparity after the comma is positive, or D5.6 if it is negative. Disparity is negative after every idle group.
- R6: With `tx_en`=0 and `tx_err`=1, the group is K23.7 twice.
- R7: With `tx_en`=1 and `tx_err`=1, the group is K30.7 twice.
- R8: A data byte with y=7 uses the alternate 0111/1000 sub-block in two cases: x is 17, 18 or 20 under negative disparity, or x is 11, 13 or 14 under positive disparity. Otherwise it uses the primary one.
- R9: From the edge after `loop_en` is sampled high, `ser_oe` and `ser_out` are 0. From the edge after it is sampled low, `ser_oe` is 1. Encoding and disparity carry on while loopback is active.
- R10: `rst_n` is an active-low synchronous reset. During reset, `ser_oe` and `ser_out` are 0 and `word_req` is 1. Reset sets disparity negative. The first group loaded after release is an idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_word | input | 16 | Parallel word; low byte sent first |
| tx_en | input | 1 | Transmit enable qualifier |
| tx_err | input | 1 | Transmit error qualifier |
| loop_en | input | 1 | Loopback: silences the serial output |
| word_req | output | 1 | Marks the capture/load edge, once per 20 cycles |
| ser_out | output | 1 | Serial NRZ data |
| ser_oe | output | 1 | Serial output enable |

## Verification
A word presented during a `word_req` cycle is captured at that edge. Its first bit shows on `ser_out` just after the next `word_req` edge, 20 cycles later. Bit i follows i edges after that, and a change of `loop_en` shows on `ser_oe` one edge later. The bench drives inputs and samples outputs on falling edges. It counts edges from reset release and uses that count to tie each driven word to the group loaded one reference period later. A background collector gathers 20 consecutive falling-edge samples per group, and every group is compared against a hand-derived code or checked against the tracked disparity.

// File: rtl/dual_byte_tx_framer.sv
module dual_byte_tx_framer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] tx_word,
  input  logic        tx_en,
  input  logic        tx_err,
  input  logic        loop_en,
  output logic        word_req,
  output logic        ser_out,
  output logic        ser_oe
);
  localparam int SYM_W = 10;
  localparam int GRP_W = 2 * SYM_W;
  localparam int CNT_W = $clog2(GRP_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRP_W - 1);

  localparam logic [7:0] K28_5 = 8'hBC;
  localparam logic [7:0] K23_7 = 8'hF7;
  localparam logic [7:0] K30_7 = 8'hFE;
  localparam logic [7:0] D16_2 = 8'h50;
  localparam logic [7:0] D5_6  = 8'hC5;

  function automatic logic [5:0] six_neg(input logic [4:0] x);
    case (x)
      5'd0:  return 6'b100111;
      5'd1:  return 6'b011101;
      5'd2:  return 6'b101101;
      5'd3:  return 6'b110001;
      5'd4:  return 6'b110101;
      5'd5:  return 6'b101001;
      5'd6:  return 6'b011001;
      5'd7:  return 6'b111000;
      5'd8:  return 6'b111001;
      5'd9:  return 6'b100101;
      5'd10: return 6'b010101;
      5'd11: return 6'b110100;
      5'd12: return 6'b001101;
      5'd13: return 6'b101100;
      5'd14: return 6'b011100;
      5'd15: return 6'b010111;
      5'd16: return 6'b011011;
      5'd17: return 6'b100011;
      5'd18: return 6'b010011;
      5'd19: return 6'b110010;
      5'd20: return 6'b001011;
      5'd21: return 6'b101010;
      5'd22: return 6'b011010;
      5'd23: return 6'b111010;
      5'd24: return 6'b110011;
      5'd25: return 6'b100110;
      5'd26: return 6'b010110;
      5'd27: return 6'b110110;
      5'd28: return 6'b001110;
      5'd29: return 6'b101110;
      5'd30: return 6'b011110;
      default: return 6'b101011;
    endcase
  endfunction

  function automatic logic [3:0] four_neg(input logic [2:0] y, input logic k, input logic alt);
    if (k) begin
      case (y)
        3'd0: return 4'b1011;
        3'd1: return 4'b0110;
        3'd2: return 4'b1010;
        3'd3: return 4'b1100;
        3'd4: return 4'b1101;
        3'd5: return 4'b0101;
        3'd6: return 4'b1001;
        default: return 4'b0111;
      endcase
    end
    case (y)
      3'd0: return 4'b1011;
      3'd1: return 4'b1001;
      3'd2: return 4'b0101;
      3'd3: return 4'b1100;
      3'd4: return 4'b1101;
      3'd5: return 4'b1010;
      3'd6: return 4'b0110;
      default: return alt ? 4'b0111 : 4'b1110;
    endcase
  endfunction

  // returns {disparity negative after symbol, symbol with bit 0 sent first}
  function automatic logic [SYM_W:0] encode(input logic [7:0] d, input logic k, input logic rdn);
    logic [4:0] x;
    logic [2:0] y;
    logic [5:0] s6;
    logic [3:0] s4;
    logic rd1, rd2, alt;
    logic [SYM_W-1:0] sym;
    x = d[4:0];
    y = d[7:5];
    s6 = (k && x == 5'd28) ? 6'b001111 : six_neg(x);
    if (!rdn && ($countones(s6) != 3 || x == 5'd7)) s6 = ~s6;
    rd1 = ($countones(s6) == 3) ? rdn : !rdn;
    alt = (rd1 && (x == 5'd17 || x == 5'd18 || x == 5'd20)) ||
          (!rd1 && (x == 5'd11 || x == 5'd13 || x == 5'd14));
    s4 = four_neg(y, k, alt);
    if (!rd1 && (k || $countones(s4) != 2 || y == 3'd3)) s4 = ~s4;
    rd2 = ($countones(s4) == 2) ? rd1 : !rd1;
    for (int i = 0; i < 6; i++) sym[i] = s6[5-i];
    for (int i = 0; i < 4; i++) sym[6+i] = s4[3-i];
    return {rd2, sym};
  endfunction

  logic [CNT_W-1:0] phase;
  logic [15:0]      word_q;
  logic             en_q, err_q, rd_neg, oe_q;
  logic [GRP_W-1:0] shreg;
  logic [7:0]       lo_byte, hi_byte;
  logic             lo_k, hi_k;
  logic [SYM_W:0]   lo_out, hi_out;
  logic [SYM_W-1:0] lo_sym, hi_sym;
  logic             lo_rd_neg;

  assign lo_k    = !en_q || err_q;
  assign hi_k    = err_q;
  assign lo_byte = !lo_k ? word_q[7:0] : (!err_q ? K28_5 : (en_q ? K30_7 : K23_7));
  assign lo_out  = encode(lo_byte, lo_k, rd_neg);
  assign lo_sym  = lo_out[SYM_W-1:0];
  assign lo_rd_neg = lo_out[SYM_W];
  assign hi_byte = err_q ? lo_byte : (en_q ? word_q[15:8] : (lo_rd_neg ? D5_6 : D16_2));
  assign hi_out  = encode(hi_byte, hi_k, lo_rd_neg);
  assign hi_sym  = hi_out[SYM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= LAST;
      word_q <= '0;
      en_q   <= 1'b0;
      err_q  <= 1'b0;
      rd_neg <= 1'b1;
      shreg  <= '0;
      oe_q   <= 1'b0;
    end else begin
      oe_q <= !loop_en;
      if (word_req) begin
        phase  <= '0;
        word_q <= tx_word;
        en_q   <= tx_en;
        err_q  <= tx_err;
        rd_neg <= hi_out[SYM_W];
        shreg  <= {hi_sym, lo_sym};
      end else begin
        phase <= phase + 1'b1;
        shreg <= {1'b0, shreg[GRP_W-1:1]};
      end
    end
  end

  assign word_req = (phase == LAST);
  assign ser_oe   = oe_q;
  assign ser_out  = oe_q & shreg[0];
endmodule

module dual_byte_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_en,
  input logic       word_req,
  input logic       ser_out,
  input logic       ser_oe,
  input logic       en_q,
  input logic       err_q,
  input logic       rd_neg,
  input logic [9:0] lo_sym,
  input logic [9:0] hi_sym
);
  logic [4:0] gap;
  logic       in_rst_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gap <= '0;
    else        gap <= word_req ? 5'd0 : gap + 5'd1;
    in_rst_q <= !rst_n;
  end

  assert_req_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |=> !word_req);
  assert_req_due_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_req && gap == 5'd18) |=> word_req);
  assert_req_early_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!word_req && gap < 5'd18) |=> !word_req);

  assert_symbol_weight_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_req |-> ($countones(lo_sym) >= 4 && $countones(lo_sym) <= 6 &&
                  $countones(hi_sym) >= 4 && $countones(hi_sym) <= 6));

  assert_idle_ends_neg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !en_q && !err_q) |=> rd_neg);

  assert_extend_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && !en_q && err_q) |-> lo_sym == hi_sym);

  assert_error_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_req && en_q && err_q) |-> lo_sym == hi_sym);

  assert_loop_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |=> (!ser_oe && !ser_out));
  assert_loop_drive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> ser_oe);

  always @(posedge clk)
    if (in_rst_q && !rst_n)
      assert_reset_state_R10: assert (!ser_oe && !ser_out && word_req && rd_neg);
endmodule

bind dual_byte_tx_framer dual_byte_tx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .loop_en(loop_en), .word_req(word_req),
  .ser_out(ser_out), .ser_oe(ser_oe), .en_q(en_q), .err_q(err_q),
  .rd_neg(rd_neg), .lo_sym(lo_sym), .hi_sym(hi_sym)
);

// File: tb/dual_byte_tx_framer_tb.sv
module dual_byte_tx_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tx_word = '0;
  logic        tx_en = 1'b0;
  logic        tx_err = 1'b0;
  logic        loop_en = 1'b0;
  logic        word_req, ser_out, ser_oe;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int rel0 = 0;
  int gdone = 0;
  bit coll_on = 0;
  bit ended = 0;
  logic [19:0] groups [0:1023];

  // groups are written in transmission order, first bit leftmost
  localparam logic [19:0] IDLE_N = 20'b0011111010_1001000101;
  localparam logic [19:0] IDLE_P = 20'b1100000101_1010010110;
  localparam logic [19:0] EXT_N  = 20'b1110101000_1110101000;
  localparam logic [19:0] EXT_P  = 20'b0001010111_0001010111;
  localparam logic [19:0] ERR_N  = 20'b0111101000_0111101000;
  localparam logic [19:0] ERR_P  = 20'b1000010111_1000010111;

  always #5 clk = ~clk;

  dual_byte_tx_framer u_dut (
    .clk(clk), .rst_n(rst_n), .tx_word(tx_word), .tx_en(tx_en), .tx_err(tx_err),
    .loop_en(loop_en), .word_req(word_req), .ser_out(ser_out), .ser_oe(ser_oe)
  );

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    wait (coll_on);
    while (coll_on) begin
      logic [19:0] g;
      g = '0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        g = {g[18:0], ser_out};
      end
      groups[gdone] = g;
      gdone = gdone + 1;
    end
  end

  task automatic chk(input string tag, input logic [19:0] got, input logic [19:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%b exp=%b", tag, got, exp);
    end
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic drive(input logic e, input logic r, input logic [15:0] w, output int gi);
    @(negedge clk);
    while (!word_req) @(negedge clk);
    tx_en = e; tx_err = r; tx_word = w;
    gi = (cyc - rel0) / 20 + 1;
  endtask

  task automatic balance(input string tag, input logic [19:0] g, inout logic rdn);
    for (int s = 0; s < 2; s++) begin
      logic [9:0] sym;
      int n;
      sym = (s == 0) ? g[19:10] : g[9:0];
      n = $countones(sym);
      checks++;
      if (!(n == 5 || (rdn && n == 6) || (!rdn && n == 4))) begin
        fails++;
        $display("FAIL %s symbol=%b ones=%0d expected 5 or %0d", tag, sym, n, rdn ? 6 : 4);
      end
      if (n != 5) rdn = !rdn;
    end
  endtask

  task automatic test_period();
    for (int t = 0; t < 2; t++) begin
      int n;
      n = 0;
      @(negedge clk);
      while (!word_req) @(negedge clk);
      @(negedge clk); n = 1;
      while (!word_req) begin @(negedge clk); n++; end
      chk("R1 word_req spacing", 20'(n), 20'd20);
    end
  endtask

  task automatic test_first_idle();
    wait (gdone > 1);
    chk("R10 first group after reset is idle", groups[0], IDLE_N);
    chk("R5 idle from negative disparity", groups[1], IDLE_N);
  endtask

  task automatic test_data();
    int a, b, c, d;
    drive(1, 0, 16'hB500, a);
    drive(1, 0, 16'hEBE7, b);
    drive(1, 0, 16'h00F1, c);
    drive(0, 0, 16'h0000, d);
    wait (gdone > d);
    chk("R3 R2 D0.0 D21.5", groups[a], 20'b1001110100_1010101010);
    chk("R8 D7.7 then D11.7 alternate", groups[b], 20'b1110001110_1101001000);
    chk("R8 R4 D17.7 alternate then D0.0 positive", groups[c], 20'b1000110111_0110001011);
    chk("R5 idle from positive disparity", groups[d], IDLE_P);
  endtask

  task automatic test_codes();
    int a, b, c, d, e, f;
    drive(0, 1, 16'h1234, a);
    drive(1, 1, 16'h5678, b);
    drive(1, 0, 16'hB5E7, c);
    drive(1, 1, 16'h0000, d);
    drive(0, 1, 16'h0000, e);
    drive(0, 0, 16'h0000, f);
    wait (gdone > f);
    chk("R6 extend from negative", groups[a], EXT_N);
    chk("R7 error from negative", groups[b], ERR_N);
    chk("R4 D7.7 D21.5 leaves positive", groups[c], 20'b1110001110_1010101010);
    chk("R7 error from positive", groups[d], ERR_P);
    chk("R6 extend from positive", groups[e], EXT_P);
    chk("R5 idle after positive run", groups[f], IDLE_P);
  endtask

  task automatic test_stream();
    int first, last, tmp;
    logic rdn;
    drive(1, 0, 16'($urandom), first);
    for (int i = 1; i < 48; i++) drive(1, 0, 16'($urandom), tmp);
    drive(0, 0, 16'h0000, last);
    wait (gdone > last);
    rdn = 1'b1;
    for (int i = first; i < last; i++) balance("R4 stream balance", groups[i], rdn);
    chk("R5 R4 idle follows tracked disparity", groups[last], rdn ? IDLE_N : IDLE_P);
  endtask

  task automatic test_loop();
    int a, b, c, d;
    drive(1, 0, 16'hB5E7, a);
    loop_en = 1'b1;
    @(negedge clk);
    chk("R9 output enable drops", {19'd0, ser_oe}, 20'd0);
    chk("R9 output quiet", {19'd0, ser_out}, 20'd0);
    drive(0, 1, 16'h0000, b);
    drive(0, 1, 16'h0000, c);
    drive(0, 0, 16'h0000, d);
    loop_en = 1'b0;
    @(negedge clk);
    chk("R9 output enable returns", {19'd0, ser_oe}, 20'd1);
    wait (gdone > d);
    chk("R9 data group silenced", groups[a], 20'd0);
    chk("R9 extend group silenced", groups[b], 20'd0);
    chk("R9 disparity kept during loopback", groups[c], EXT_P);
    chk("R9 R5 idle after loopback", groups[d], IDLE_P);
  endtask

  task automatic test_reset_mid();
    int a, b;
    logic [19:0] g0, g1;
    drive(1, 0, 16'hB5E7, a);
    drive(0, 1, 16'h0000, b);
    wait (gdone > a);
    coll_on = 0;
    repeat (25) @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 enable low in reset", {19'd0, ser_oe}, 20'd0);
    chk("R10 word_req high in reset", {19'd0, word_req}, 20'd1);
    rst_n = 1'b1;
    g0 = '0; g1 = '0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); g0 = {g0[18:0], ser_out}; end
    for (int i = 0; i < 20; i++) begin @(negedge clk); g1 = {g1[18:0], ser_out}; end
    chk("R10 idle after mid-run reset", g0, IDLE_N);
    chk("R10 disparity negative after reset", g1, EXT_N);
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired, run did not complete");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 enable low in reset", {19'd0, ser_oe}, 20'd0);
    chk("R10 output low in reset", {19'd0, ser_out}, 20'd0);
    chk("R10 word_req high in reset", {19'd0, word_req}, 20'd1);
    rst_n = 1'b1;
    rel0 = cyc;
    coll_on = 1;
    test_period();
    test_first_idle();
    test_data();
    test_codes();
    test_stream();
    test_loop();
    test_reset_mid();
    finish_up();
  end
endmodule